// File: doc/BRIEF.md
# Function-Unit Scoreboard with Write Handshake

This block tracks hazards for a small pool of function units that share one register file. Each instruction is accepted on an issue stream and placed on the lowest-numbered idle unit. From then on the block tells that unit when its operands may be read and when its finished result may be written back. The arithmetic inside the units lies outside the block. Each unit keeps its result in its own output latch until the block lets it write. Those latches act as renaming: a unit that overwrites a register an older unit still has to read can finish early and hold its value there.

Two structures hold the state. A unit-to-register table records, for every unit, the registers it has still to read and the register it will write. A unit-to-unit table records three kinds of dependency on older units: read-after-write, write-after-read and write-after-write. Dependencies are recorded only toward units that are already busy, so the unit-to-unit graph cannot form a cycle. A unit may request the write port once it has read its operands, its result is valid, and no write-after-read or write-after-write dependency remains. A fixed-priority arbiter grants one single-cycle write per cycle. At the next clock edge the request drops, the unit's entries are erased from both tables, and the unit becomes free.

The issue side is a valid/ready stream. While `iss_valid` is high and `iss_ready` is low, the issuer holds the fields stable. The result side is also a handshake: `res_valid[u]` acts as valid and `go_write[u]` acts as ready. A unit raises `res_valid[u]`, keeps it high with its data stable, and drops it only after the cycle in which `go_write[u]` was high.

Top module: `fu_scoreboard`

## Requirements
- R1: Reset state. After reset every unit is idle: `unit_busy`, `go_read`, `go_write` and `wr_en` are all zero and `iss_ready` is one.
- R2: Issue. An instruction is accepted on a clock edge where `iss_valid` and `iss_ready` are both high. It goes to the lowest-numbered idle unit, and that index is shown on `iss_unit` in the accepting cycle. `iss_ready` is low only while every unit is busy. While it is low, nothing is accepted and the busy set does not change.
- R3: Operand read. A newly issued unit with no pending producer for either of its sources raises `go_read` in the cycle right after acceptance. `go_read` is a one-cycle pulse that happens once per issue.
- R4: Read-after-write. A unit whose source is the destination of an older unit that has not written yet holds `go_read` low. It pulses `go_read` in the cycle right after that producer's `go_write` cycle.
- R5: Write-after-read. A unit whose destination is a source that an older unit has not read yet may read operands and hold a valid result, but gets no `go_write`. Its `go_write` comes no earlier than two cycles after the older unit's `go_read` cycle.
- R6: Write-after-write. Two units that target the same destination write it in issue order. The younger unit's `go_write` comes no earlier than two cycles after the older unit's `go_write`.
- R7: Write grant. `go_write` is high for at most one unit per cycle and for exactly one cycle per issue. When several units request together, the lowest-numbered unit wins. In a grant cycle, `wr_en` is 1, `wr_addr` is the granted unit's destination, and `wr_data` is that unit's slice `res_data[u*DW +: DW]`.
- R8: Release. In the cycle after its `go_write`, a unit shows `unit_busy` low, no longer blocks any other unit, and can be chosen again on the issue stream.
- R9: Result handshake. A unit gets no `go_write` unless `res_valid` for it is high. The write request is registered, so for a unit that has already read its operands, `go_write` comes at the earliest in the cycle after the first cycle in which `res_valid` is high. For a unit that has just been issued with no hazards and `res_valid` already high, `go_write` comes two cycles after its `go_read`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue stream valid |
| iss_ready | output | 1 | An idle unit is available |
| iss_src_a | input | log2(NREG) | First source register |
| iss_src_b | input | log2(NREG) | Second source register |
| iss_dst | input | log2(NREG) | Destination register |
| iss_unit | output | log2(NFU) | Unit that the present issue would occupy |
| unit_busy | output | NFU | Per-unit busy flags |
| go_read | output | NFU | Per-unit operand read pulse |
| res_valid | input | NFU | Per-unit result held in the output latch |
| res_data | input | NFU*DW | Per-unit result data, unit u in slice u*DW |
| go_write | output | NFU | Per-unit single-cycle write grant |
| wr_en | output | 1 | Register file write enable |
| wr_addr | output | log2(NREG) | Register file write address |
| wr_data | output | DW | Register file write data |

## Verification
The assertions assume the result side follows its handshake. `res_valid[u]` stays high from the first cycle it is raised through the cycle of `go_write[u]`. It is never raised for an idle unit. The stimulus raises a unit's `res_valid` only after that unit has been issued. It keeps it high until the cycle after the grant, and no earlier, and changes `res_data` only while no grant is pending. The issue fields change only after a clock edge and are held while `iss_ready` is low. The hazard scenarios build each dependency kind separately, so each expected grant cycle can be worked out by hand.

// File: rtl/fu_sb_pkg.sv
package fu_sb_pkg;
  localparam int SB_NFU  = 4;
  localparam int SB_NREG = 8;
  localparam int SB_DW   = 16;
endpackage

// File: rtl/sb_prio_pick.sv
module sb_prio_pick #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign grant[k]  = req[k] & ~seen[k];
    assign seen[k+1] = seen[k] | req[k];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/sb_reg_matrix.sv
module sb_reg_matrix #(
  parameter  int NFU  = 4,
  parameter  int NREG = 8,
  localparam int FW   = (NFU > 1) ? $clog2(NFU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_we,
  input  logic [FW-1:0]             iss_unit,
  input  logic [NREG-1:0]           src_mask,
  input  logic [NREG-1:0]           dst_mask,
  input  logic [NFU-1:0]            busy,
  input  logic [NFU-1:0]            read_clr,
  input  logic [NFU-1:0]            release_v,
  output logic [NFU-1:0][NREG-1:0]  rd_pend,
  output logic [NFU-1:0][NREG-1:0]  wr_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= '0;
      wr_pend <= '0;
    end else begin
      for (int u = 0; u < NFU; u++) begin
        if (release_v[u]) begin
          rd_pend[u] <= '0;
          wr_pend[u] <= '0;
        end else if (read_clr[u]) begin
          rd_pend[u] <= '0;
        end
      end
      if (iss_we) begin
        rd_pend[iss_unit] <= src_mask;
        wr_pend[iss_unit] <= dst_mask;
      end
    end
  end

  for (genvar u = 0; u < NFU; u++) begin : g_chk
    // An idle unit holds no register claims (R8)
    assert_idle_no_claims_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[u] |-> (rd_pend[u] == '0 && wr_pend[u] == '0));
  end
endmodule

// File: rtl/sb_dep_matrix.sv
module sb_dep_matrix #(
  parameter  int NFU  = 4,
  parameter  int NREG = 8,
  localparam int FW   = (NFU > 1) ? $clog2(NFU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_we,
  input  logic [FW-1:0]             iss_unit,
  input  logic [NREG-1:0]           src_mask,
  input  logic [NREG-1:0]           dst_mask,
  input  logic [NFU-1:0]            busy,
  input  logic [NFU-1:0][NREG-1:0]  rd_pend,
  input  logic [NFU-1:0][NREG-1:0]  wr_pend,
  input  logic [NFU-1:0]            read_clr,
  input  logic [NFU-1:0]            release_v,
  output logic [NFU-1:0]            raw_hold,
  output logic [NFU-1:0]            wr_hold
);
  logic [NFU-1:0][NFU-1:0] raw_m, war_m, waw_m;
  logic [NFU-1:0]          row_raw, row_war, row_waw;

  // New row for the issuing unit: only units staying busy past this edge count
  always_comb begin
    for (int i = 0; i < NFU; i++) begin
      row_raw[i] = busy[i] & ~release_v[i] & (|(wr_pend[i] & src_mask));
      row_waw[i] = busy[i] & ~release_v[i] & (|(wr_pend[i] & dst_mask));
      row_war[i] = busy[i] & ~release_v[i] & ~read_clr[i] & (|(rd_pend[i] & dst_mask));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_m <= '0;
      war_m <= '0;
      waw_m <= '0;
    end else begin
      for (int r = 0; r < NFU; r++) begin
        for (int c = 0; c < NFU; c++) begin
          raw_m[r][c] <= raw_m[r][c] & ~release_v[c] & ~release_v[r];
          waw_m[r][c] <= waw_m[r][c] & ~release_v[c] & ~release_v[r];
          war_m[r][c] <= war_m[r][c] & ~release_v[c] & ~release_v[r] & ~read_clr[c];
        end
      end
      if (iss_we) begin
        raw_m[iss_unit] <= row_raw;
        war_m[iss_unit] <= row_war;
        waw_m[iss_unit] <= row_waw;
      end
    end
  end

  for (genvar u = 0; u < NFU; u++) begin : g_hold
    assign raw_hold[u] = |raw_m[u];
    assign wr_hold[u]  = (|war_m[u]) | (|waw_m[u]);

    // Idle units keep an empty row (R8)
    assert_idle_row_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[u] |-> (raw_m[u] == '0 && war_m[u] == '0 && waw_m[u] == '0));
    // No unit ever waits on itself (R6)
    assert_no_self_dep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(raw_m[u][u] | war_m[u][u] | waw_m[u][u]));
  end
endmodule

// File: rtl/fu_scoreboard.sv
module fu_scoreboard
  import fu_sb_pkg::*;
#(
  parameter  int NFU  = SB_NFU,
  parameter  int NREG = SB_NREG,
  parameter  int DW   = SB_DW,
  localparam int FW   = (NFU > 1) ? $clog2(NFU) : 1,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [RW-1:0]     iss_src_a,
  input  logic [RW-1:0]     iss_src_b,
  input  logic [RW-1:0]     iss_dst,
  output logic [FW-1:0]     iss_unit,
  output logic [NFU-1:0]    unit_busy,
  output logic [NFU-1:0]    go_read,
  input  logic [NFU-1:0]    res_valid,
  input  logic [NFU*DW-1:0] res_data,
  output logic [NFU-1:0]    go_write,
  output logic              wr_en,
  output logic [RW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data
);
  logic [NFU-1:0]           busy, rd_done, wreq_q;
  logic [NFU-1:0]           free_grant, raw_hold, wr_hold;
  logic                     free_any, iss_we;
  logic [FW-1:0]            free_idx, wr_sel;
  logic [NFU-1:0][RW-1:0]   dst_q;
  logic [NREG-1:0]          src_mask, dst_mask;
  logic [NFU-1:0][NREG-1:0] rd_pend, wr_pend;

  for (genvar r = 0; r < NREG; r++) begin : g_dec
    assign src_mask[r] = (iss_src_a == RW'(r)) | (iss_src_b == RW'(r));
    assign dst_mask[r] = (iss_dst == RW'(r));
  end

  sb_prio_pick #(.N(NFU)) u_free (
    .req(~busy), .grant(free_grant), .any(free_any), .idx(free_idx)
  );

  assign iss_ready = free_any;
  assign iss_unit  = free_idx;
  assign iss_we    = iss_valid & free_any;
  assign unit_busy = busy;

  sb_reg_matrix #(.NFU(NFU), .NREG(NREG)) u_regm (
    .clk(clk), .rst_n(rst_n), .iss_we(iss_we), .iss_unit(free_idx),
    .src_mask(src_mask), .dst_mask(dst_mask), .busy(busy),
    .read_clr(go_read), .release_v(go_write),
    .rd_pend(rd_pend), .wr_pend(wr_pend)
  );

  sb_dep_matrix #(.NFU(NFU), .NREG(NREG)) u_depm (
    .clk(clk), .rst_n(rst_n), .iss_we(iss_we), .iss_unit(free_idx),
    .src_mask(src_mask), .dst_mask(dst_mask), .busy(busy),
    .rd_pend(rd_pend), .wr_pend(wr_pend),
    .read_clr(go_read), .release_v(go_write),
    .raw_hold(raw_hold), .wr_hold(wr_hold)
  );

  assign go_read = busy & ~rd_done & ~raw_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= '0;
      rd_done <= '0;
      wreq_q  <= '0;
      dst_q   <= '0;
    end else begin
      busy <= (busy | (iss_we ? free_grant : '0)) & ~go_write;
      for (int u = 0; u < NFU; u++) begin
        if (iss_we && free_grant[u]) begin
          rd_done[u] <= 1'b0;
          dst_q[u]   <= iss_dst;
        end else if (go_read[u]) begin
          rd_done[u] <= 1'b1;
        end
        if (go_write[u])
          wreq_q[u] <= 1'b0;
        else if (busy[u] && rd_done[u] && res_valid[u] && !wr_hold[u])
          wreq_q[u] <= 1'b1;
      end
    end
  end

  sb_prio_pick #(.N(NFU)) u_warb (
    .req(wreq_q), .grant(go_write), .any(wr_en), .idx(wr_sel)
  );

  assign wr_addr = wr_en ? dst_q[wr_sel] : '0;
  assign wr_data = res_data[int'(wr_sel)*DW +: DW];

  assert_accept_marks_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> busy[$past(iss_unit)]);

  for (genvar u = 0; u < NFU; u++) begin : g_chk
    assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      go_read[u] |=> !go_read[u]);
    assert_grant_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      go_write[u] |=> !go_write[u]);
    assert_grant_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
      go_write[u] |=> !unit_busy[u]);
    assert_grant_has_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      go_write[u] |-> res_valid[u]);
  end
endmodule

// File: tb/fu_scoreboard_bench.sv
module fu_scoreboard_bench;
  localparam int NFU = 4, NREG = 8, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic iss_ready;
  logic [2:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
  logic [1:0] iss_unit;
  logic [NFU-1:0] unit_busy, go_read, go_write;
  logic [NFU-1:0] res_valid = '0;
  logic [NFU*DW-1:0] res_data = '0;
  logic wr_en;
  logic [2:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fu_scoreboard u_fu_scoreboard (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
    .iss_unit(iss_unit), .unit_busy(unit_busy), .go_read(go_read),
    .res_valid(res_valid), .res_data(res_data), .go_write(go_write),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  localparam int NV = 4;
  localparam int V_A[NV]    = '{1, 2, 7, 0};
  localparam int V_B[NV]    = '{3, 2, 6, 5};
  localparam int V_D[NV]    = '{4, 0, 7, 5};
  localparam int V_DATA[NV] = '{16'h1234, 16'hBEEF, 16'h00FF, 16'hA5A5};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic issue(input int a, input int b, input int d);
    iss_valid = 1'b1;
    iss_src_a = 3'(a);
    iss_src_b = 3'(b);
    iss_dst   = 3'(d);
  endtask

  task automatic set_res(input int u, input int data);
    res_valid[u] = 1'b1;
    res_data[u*DW +: DW] = DW'(data);
  endtask

  task automatic wait_write(input int u);
    for (int n = 0; n < 30; n++) begin
      tick();
      if (go_write[u]) return;
    end
    chk("R7 drain grant", 0, 1);
  endtask

  task automatic drain(input int u, input int data);
    set_res(u, data);
    wait_write(u);
    tick();
    res_valid[u] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 iss_ready", int'(iss_ready), 1);
    chk("R1 unit_busy", int'(unit_busy), 0);
    chk("R1 go_read", int'(go_read), 0);
    chk("R1 go_write", int'(go_write), 0);
    chk("R1 wr_en", int'(wr_en), 0);

    // Vector walk: isolated instruction lifecycles
    for (int v = 0; v < NV; v++) begin
      issue(V_A[v], V_B[v], V_D[v]);
      chk("R2 ready", int'(iss_ready), 1);
      chk("R2 unit", int'(iss_unit), 0);
      tick();
      iss_valid = 1'b0;
      chk("R2 busy", int'(unit_busy), 1);
      chk("R3 go_read", int'(go_read), 1);
      set_res(0, V_DATA[v]);
      tick();
      chk("R3 pulse", int'(go_read), 0);
      chk("R9 no early grant", int'(go_write), 0);
      tick();
      chk("R7 grant", int'(go_write), 1);
      chk("R7 wr_en", int'(wr_en), 1);
      chk("R7 wr_addr", int'(wr_addr), V_D[v]);
      chk("R7 wr_data", int'(wr_data), V_DATA[v]);
      tick();
      res_valid[0] = 1'b0;
      chk("R8 freed", int'(unit_busy), 0);
      chk("R7 single", int'(wr_en), 0);
    end

    // R4 read-after-write
    issue(0, 0, 3);
    tick();
    issue(3, 1, 4);
    chk("R2 second unit", int'(iss_unit), 1);
    tick();
    iss_valid = 1'b0;
    chk("R4 reader held", int'(go_read[1]), 0);
    repeat (3) tick();
    chk("R4 still held", int'(go_read[1]), 0);
    chk("R9 no result no grant", int'(go_write), 0);
    set_res(0, 16'h3333);
    tick();
    chk("R9 grant next cycle", int'(go_write), 1);
    chk("R4 held in grant", int'(go_read[1]), 0);
    tick();
    res_valid[0] = 1'b0;
    chk("R4 read after write", int'(go_read), 2);
    chk("R8 producer free", int'(unit_busy), 2);
    drain(1, 16'h4444);

    // R5 write-after-read
    issue(0, 0, 5);
    tick();
    issue(5, 7, 6);
    tick();
    issue(0, 0, 7);
    chk("R2 third unit", int'(iss_unit), 2);
    tick();
    iss_valid = 1'b0;
    chk("R3 no-hazard read", int'(go_read), 4);
    set_res(2, 16'hC0DE);
    repeat (3) tick();
    chk("R5 early result held", int'(go_write), 0);
    set_res(0, 16'h5555);
    tick();
    chk("R5 older writes", int'(go_write), 1);
    tick();
    res_valid[0] = 1'b0;
    chk("R5 reader reads", int'(go_read), 2);
    chk("R5 still held", int'(go_write), 0);
    tick();
    chk("R5 one more cycle", int'(go_write), 0);
    tick();
    chk("R5 grant", int'(go_write), 4);
    chk("R5 wr_addr", int'(wr_addr), 7);
    chk("R5 wr_data", int'(wr_data), 16'hC0DE);
    tick();
    res_valid[2] = 1'b0;
    drain(1, 16'h6666);

    // R6 write-after-write
    issue(0, 0, 2);
    tick();
    issue(1, 1, 2);
    tick();
    iss_valid = 1'b0;
    set_res(0, 16'hAAAA);
    set_res(1, 16'hBBBB);
    tick();
    chk("R6 older first", int'(go_write), 1);
    chk("R6 older data", int'(wr_data), 16'hAAAA);
    tick();
    res_valid[0] = 1'b0;
    chk("R6 gap", int'(go_write), 0);
    tick();
    chk("R6 younger", int'(go_write), 2);
    chk("R6 addr", int'(wr_addr), 2);
    chk("R6 younger data", int'(wr_data), 16'hBBBB);
    tick();
    res_valid[1] = 1'b0;

    // R7 priority among simultaneous requests
    issue(0, 0, 1);
    tick();
    issue(0, 0, 3);
    tick();
    iss_valid = 1'b0;
    tick();
    set_res(0, 16'h0101);
    set_res(1, 16'h0303);
    tick();
    chk("R7 lowest wins", int'(go_write), 1);
    tick();
    res_valid[0] = 1'b0;
    chk("R7 loser next", int'(go_write), 2);
    chk("R7 loser addr", int'(wr_addr), 3);
    tick();
    res_valid[1] = 1'b0;
    chk("R8 all free", int'(unit_busy), 0);

    // R2 full stall, R8 reissue
    for (int u = 0; u < NFU; u++) begin
      issue(u, u, u);
      tick();
    end
    issue(6, 6, 6);
    chk("R2 stall ready", int'(iss_ready), 0);
    chk("R2 all busy", int'(unit_busy), 15);
    repeat (3) tick();
    chk("R2 nothing accepted", int'(unit_busy), 15);
    set_res(2, 16'h2222);
    wait_write(2);
    tick();
    res_valid[2] = 1'b0;
    chk("R8 reissue ready", int'(iss_ready), 1);
    chk("R8 reissue unit", int'(iss_unit), 2);
    tick();
    iss_valid = 1'b0;
    chk("R8 refilled", int'(unit_busy), 15);
    for (int u = 0; u < NFU; u++) drain(u, 16'h7000 + u);
    chk("R8 drained", int'(unit_busy), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule